// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a down-counting watchdog that software controls through four 16-bit registers on a simple word-addressed write/read bus. A prescaler divides the clock into a fixed tick (0.6 s in the intended system, which is a time in seconds times 10/6 ticks). A programmable start value sets how many ticks the counter runs before it expires. Software keeps the system alive by writing anything to the counter register, which puts the start value back into the counter. A read of the same register returns the live count.

Expiry has two stages. The first expiry sets a timeout flag, optionally pulses an interrupt request, and starts a new period on its own. If the counter expires again before software has cleared that flag, the block asserts a reset request and holds it. An external reboot-inhibit input can block that reset. The count keeps running while the reset is blocked, and a separate flag records each reset that was blocked. A halt bit freezes the count. The halt bit is set out of reset, so the watchdog does nothing until software starts it.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the halt bit is 1, the interrupt enable is 0, the start value and the counter both equal DEFAULT_LOAD, all three flags are 0, and irq_pulse and rst_req are low.
- R2: A write to the start-value register (word address 1) is ignored as a whole when its bits [CNT_W-1:0] are below MIN_LOAD. An accepted write stores all 16 bits, and a read returns them as written.
- R3: While the halt bit (control register, word address 2, bit 0) is 1, the counter does not change, except that a write to the counter register still loads it with the start value.
- R4: With the halt bit at 0, the counter drops by one every TICK_CLKS clocks, counted from the edge that took the last counter write or the clear of the halt bit. A read of word address 0 returns the count in bits [CNT_W-1:0].
- R5: A tick that finds the count at 1 is an expiry, and the counter takes the start value again. At the first expiry the flag at bit 0 of the flag register (word address 3) is set. If the interrupt enable (control bit 1) is 1, irq_pulse goes high for exactly one clock, starting on that expiry edge.
- R6: With the interrupt enable at 0, an expiry still sets the timeout flag, but irq_pulse stays low.
- R7: An expiry while flag bit 0 is already set sets flag bit 1 and raises rst_req. rst_req then stays high until reset.
- R8: While reboot_block is 1, such a second expiry leaves rst_req low, sets flag bit 2 in its place, and the counter keeps counting.
- R9: A flag clears only when its bit is written as 1 to the flag register. Zero bits leave flags unchanged. Once bit 0 has been cleared, the next expiry counts as a first expiry again.
- R10: A counter-register write on the same clock as a tick loads the start value with no decrement, and the next tick comes TICK_CLKS clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for one clock |
| bus_addr | input | 2 | Word address: 0 counter, 1 start value, 2 control, 3 flags |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| reboot_block | input | 1 | High blocks the reset request |
| irq_pulse | output | 1 | One-clock interrupt request on a first expiry |
| rst_req | output | 1 | Sticky reset request after a second expiry |

## Verification
The hardest case to reach is a counter write that lands on the exact clock on which a tick is due, because the tick comes from a hidden prescaler phase. The bench makes it reachable by using the rule that a counter write or a release of the halt bit restarts the prescaler. Each scenario starts from a counter write, so every later tick edge is a known multiple of TICK_CLKS, and the bench can place a write on a tick or sample the counter one clock before and one clock after an expiry. A sweep over every start value from the minimum up to twelve checks each intermediate count and the exact expiry edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_COUNT = 2'd0,
      REG_START = 2'd1,
      REG_CTRL  = 2'd2,
      REG_FLAGS = 2'd3
   } wd_reg_e;

   localparam int CTRL_HALT  = 0;
   localparam int CTRL_IRQEN = 1;

   localparam int FLAG_FIRST   = 0;
   localparam int FLAG_SECOND  = 1;
   localparam int FLAG_BLOCKED = 2;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
   parameter int TICK_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   generate
      if (TICK_CLKS == 1) begin : g_every_clock
         assign tick = run;
      end else begin : g_divider
         localparam int PW = $clog2(TICK_CLKS);
         localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase <= '0;
            else if (!run || restart || phase == LAST)
               phase <= '0;
            else
               phase <= phase + 1'b1;
         end

         assign tick = run && (phase == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
   parameter int CNT_W     = 10,
   parameter int RESET_VAL = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             tick,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_VAL);

   assign expire = tick && !load && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= RST_V;
      else if (load || expire)
         count <= load_val;
      else if (tick)
         count <= count - ONE;
   end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int CNT_W        = 10,
   parameter int MIN_LOAD     = 4,
   parameter int DEFAULT_LOAD = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              expire,
   input  logic              reboot_block,
   output logic              reload_wr,
   output logic              halt,
   output logic [CNT_W-1:0]  start_val,
   output logic              irq_pulse,
   output logic              rst_req
);
   localparam logic [CNT_W-1:0]  MIN_V = CNT_W'(MIN_LOAD);
   localparam logic [DATA_W-1:0] DEF_V = DATA_W'(DEFAULT_LOAD);

   wd_reg_e          sel;
   logic             wr_start, wr_ctrl, wr_flags;
   logic [DATA_W-1:0] start_q;
   logic             irq_en;
   logic             flg_first, flg_second, flg_blocked;
   logic             first_evt, second_evt;

   assign sel       = wd_reg_e'(bus_addr);
   assign reload_wr = bus_wr_en && (sel == REG_COUNT);
   assign wr_start  = bus_wr_en && (sel == REG_START);
   assign wr_ctrl   = bus_wr_en && (sel == REG_CTRL);
   assign wr_flags  = bus_wr_en && (sel == REG_FLAGS);

   assign first_evt  = expire && !flg_first;
   assign second_evt = expire && flg_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         start_q <= DEF_V;
      else if (wr_start && bus_wdata[CNT_W-1:0] >= MIN_V)
         start_q <= bus_wdata;
   end
   assign start_val = start_q[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt   <= 1'b1;
         irq_en <= 1'b0;
      end else if (wr_ctrl) begin
         halt   <= bus_wdata[CTRL_HALT];
         irq_en <= bus_wdata[CTRL_IRQEN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_first   <= 1'b0;
         flg_second  <= 1'b0;
         flg_blocked <= 1'b0;
      end else begin
         if (first_evt)
            flg_first <= 1'b1;
         else if (wr_flags && bus_wdata[FLAG_FIRST])
            flg_first <= 1'b0;

         if (second_evt)
            flg_second <= 1'b1;
         else if (wr_flags && bus_wdata[FLAG_SECOND])
            flg_second <= 1'b0;

         if (second_evt && reboot_block)
            flg_blocked <= 1'b1;
         else if (wr_flags && bus_wdata[FLAG_BLOCKED])
            flg_blocked <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pulse <= 1'b0;
         rst_req   <= 1'b0;
      end else begin
         irq_pulse <= first_evt && irq_en;
         if (second_evt && !reboot_block)
            rst_req <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         REG_COUNT: bus_rdata = DATA_W'(count);
         REG_START: bus_rdata = start_q;
         REG_CTRL: begin
            bus_rdata[CTRL_HALT]  = halt;
            bus_rdata[CTRL_IRQEN] = irq_en;
         end
         REG_FLAGS: begin
            bus_rdata[FLAG_FIRST]   = flg_first;
            bus_rdata[FLAG_SECOND]  = flg_second;
            bus_rdata[FLAG_BLOCKED] = flg_blocked;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int TICK_CLKS    = 150_000_000,
   parameter int CNT_W        = 10,
   parameter int MIN_LOAD     = 4,
   parameter int DEFAULT_LOAD = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              reboot_block,
   output logic              irq_pulse,
   output logic              rst_req
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_width
         $error("wdog_twostage: CNT_W must lie between 4 and DATA_W");
      end
      if (MIN_LOAD < 2 || MIN_LOAD > CNT_MAX) begin : g_bad_min
         $error("wdog_twostage: MIN_LOAD out of range");
      end
      if (DEFAULT_LOAD < MIN_LOAD || DEFAULT_LOAD > CNT_MAX) begin : g_bad_default
         $error("wdog_twostage: DEFAULT_LOAD out of range");
      end
      if (TICK_CLKS < 1) begin : g_bad_tick
         $error("wdog_twostage: TICK_CLKS must be at least 1");
      end
   endgenerate

   logic             reload_wr;
   logic             halt;
   logic             tick;
   logic             expire;
   logic [CNT_W-1:0] start_val;
   logic [CNT_W-1:0] cnt_val;

   wdog_regs #(
      .CNT_W        (CNT_W),
      .MIN_LOAD     (MIN_LOAD),
      .DEFAULT_LOAD (DEFAULT_LOAD)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr_en    (bus_wr_en),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .count        (cnt_val),
      .expire       (expire),
      .reboot_block (reboot_block),
      .reload_wr    (reload_wr),
      .halt         (halt),
      .start_val    (start_val),
      .irq_pulse    (irq_pulse),
      .rst_req      (rst_req)
   );

   wdog_tick_gen #(
      .TICK_CLKS (TICK_CLKS)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!halt),
      .restart (reload_wr),
      .tick    (tick)
   );

   wdog_down_cnt #(
      .CNT_W     (CNT_W),
      .RESET_VAL (DEFAULT_LOAD)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (reload_wr),
      .tick     (tick),
      .load_val (start_val),
      .count    (cnt_val),
      .expire   (expire)
   );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             halt,
   input logic             reload_wr,
   input logic [CNT_W-1:0] start_val,
   input logic [CNT_W-1:0] cnt_val,
   input logic             irq_pulse,
   input logic             rst_req,
   input logic             reboot_block
);
   assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !reload_wr) |=> $stable(cnt_val));

   assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_val != '0);

   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   assert_rst_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   assert_rst_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> !$past(reboot_block));

   assert_reload_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reload_wr |=> (cnt_val == $past(start_val)));
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .halt         (halt),
   .reload_wr    (reload_wr),
   .start_val    (start_val),
   .cnt_val      (cnt_val),
   .irq_pulse    (irq_pulse),
   .rst_req      (rst_req),
   .reboot_block (reboot_block)
);

// File: tb/wdog_twostage_tb.sv
`timescale 1ns/1ps
module wdog_twostage_tb;
   localparam int TK  = 4;
   localparam int DEF = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        reboot_block = 1'b0;
   logic        irq_pulse;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdog_twostage #(
      .TICK_CLKS(TK), .CNT_W(10), .MIN_LOAD(4), .DEFAULT_LOAD(DEF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reboot_block(reboot_block),
      .irq_pulse(irq_pulse), .rst_req(rst_req)
   );

   always @(negedge clk) if (rst_n && irq_pulse) irq_seen++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int base;
      do_reset();

      // R1 reset state
      rd(2'd2, d); chk("R1 ctrl", d, 16'h0001);
      rd(2'd1, d); chk("R1 start", d, DEF);
      rd(2'd0, d); chk("R1 count", d, DEF);
      rd(2'd3, d); chk("R1 flags", d, 16'h0000);
      chk("R1 outputs", {irq_pulse, rst_req}, 2'b00);

      // R2 small values ignored, upper bits stored
      wr(2'd1, 16'h0003); rd(2'd1, d); chk("R2 value 3 ignored", d, DEF);
      wr(2'd1, 16'h0000); rd(2'd1, d); chk("R2 value 0 ignored", d, DEF);
      wr(2'd1, 16'hFC05); rd(2'd1, d); chk("R2 upper bits kept", d, 16'hFC05);
      wr(2'd1, 16'hA002); rd(2'd1, d); chk("R2 whole write ignored", d, 16'hFC05);
      wr(2'd1, 16'h0004); rd(2'd1, d); chk("R2 minimum accepted", d, 16'h0004);

      // R3 halted: reload loads, no counting
      wr(2'd1, 16'd9); wr(2'd0, 16'h0);
      rd(2'd0, d); chk("R3 reload while halted", d, 9);
      wait_cyc(40);
      rd(2'd0, d); chk("R3 frozen while halted", d, 9);
      rd(2'd3, d); chk("R3 no expiry while halted", d, 0);

      // R4 / R5 sweep over start values
      for (int n = 4; n <= 12; n++) begin
         wr(2'd2, 16'h0003);
         wr(2'd1, 16'(n));
         wr(2'd3, 16'h0007);
         wr(2'd2, 16'h0002);
         wr(2'd0, 16'h0);
         base = irq_seen;
         for (int k = 1; k < n; k++) begin
            wait_cyc(TK);
            rd(2'd0, d); chk("R4 decrement", d, n - k);
         end
         wait_cyc(TK - 1);
         rd(2'd3, d); chk("R5 no flag before expiry", d, 0);
         chk("R5 no irq before expiry", irq_seen, base);
         wait_cyc(1);
         rd(2'd0, d); chk("R5 reload on expiry", d, n);
         rd(2'd3, d); chk("R5 first flag", d, 16'h0001);
         chk("R5 irq pulse", irq_seen, base + 1);
         wait_cyc(1);
         chk("R5 single pulse", {irq_pulse, 32'(irq_seen)}, {1'b0, 32'(base + 1)});
      end

      // R10 reload on tick cycle
      wr(2'd1, 16'd6); wr(2'd0, 16'h0);
      wait_cyc(TK - 1);
      wr(2'd0, 16'h0);
      rd(2'd0, d); chk("R10 reload beats tick", d, 6);
      wait_cyc(TK - 1);
      rd(2'd0, d); chk("R10 prescaler restarted", d, 6);
      wait_cyc(1);
      rd(2'd0, d); chk("R10 next tick", d, 5);

      // R9 write-one-to-clear
      wr(2'd2, 16'h0001);
      wr(2'd3, 16'h0007);
      wr(2'd1, 16'd4); wr(2'd2, 16'h0002); wr(2'd0, 16'h0);
      wait_cyc(4 * TK);
      wr(2'd2, 16'h0001);
      rd(2'd3, d); chk("R9 flag set", d, 16'h0001);
      wr(2'd3, 16'h0006); rd(2'd3, d); chk("R9 zero bit keeps flag", d, 16'h0001);
      wr(2'd3, 16'h0001); rd(2'd3, d); chk("R9 one clears flag", d, 16'h0000);
      wr(2'd2, 16'h0002); wr(2'd0, 16'h0);
      wait_cyc(4 * TK);
      rd(2'd3, d); chk("R9 counts as first again", d, 16'h0001);
      chk("R9 no reset", rst_req, 1'b0);

      // R8 reboot inhibit
      reboot_block = 1'b1;
      wr(2'd3, 16'h0007); wr(2'd0, 16'h0);
      wait_cyc(8 * TK);
      rd(2'd3, d); chk("R8 blocked flag", d, 16'h0007);
      chk("R8 reset held off", rst_req, 1'b0);
      wait_cyc(TK);
      rd(2'd0, d); chk("R8 keeps counting", d, 3);

      // R6 / R7
      do_reset();
      reboot_block = 1'b0;
      wr(2'd1, 16'd4); wr(2'd2, 16'h0000); wr(2'd0, 16'h0);
      base = irq_seen;
      wait_cyc(4 * TK);
      rd(2'd3, d); chk("R6 flag without irq", d, 16'h0001);
      chk("R6 irq masked", irq_seen, base);
      wait_cyc(4 * TK - 1);
      chk("R7 no reset yet", rst_req, 1'b0);
      wait_cyc(1);
      chk("R7 reset request", rst_req, 1'b1);
      rd(2'd3, d); chk("R7 second flag", d, 16'h0003);
      wr(2'd3, 16'h0007);
      wait_cyc(10);
      chk("R7 reset sticky", rst_req, 1'b1);
      do_reset();
      chk("R1 reset clears request", rst_req, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule